// File: doc/BRIEF.md
# Three-Format Radio Baseband Data Port

This block sits between a host controller and a radio modem. It carries the bit stream in both directions over a host data line, split into input, output and output-enable signals, and a host clock line. One of three line formats is selected. In plain synchronous NRZ and in synchronous Manchester the block is the clock master. It produces a bit clock from the system clock through a divider that a 3-bit rate code selects. It samples host transmit data on the rising clock edge, or it presents receive data that the host samples on that same edge.

In transparent mode nothing is retimed or encoded. Transmit bits pass from the host data line straight to the modulator. In receive, the raw demodulator level is put out on the clock pin and the data line stays released. Format and rate changes are held back until the next bit boundary, which is the falling edge of the bit clock. A change of direction restarts the bit-clock phase at once and loads the pending format and rate.

Top module: `radio_data_port`

## Requirements
- R1: While reset is asserted, and until the first divider half-period has elapsed, `dclk_out`, `dio_oe`, `dio_out` and `mod_out` are all 0. The reset format is NRZ, the reset rate code is 0 and the reset direction is transmit.
- R2: The format codes on `mode_sel` are 0 for synchronous NRZ, 1 for synchronous Manchester, and 2 or 3 for transparent. In synchronous NRZ the block drives `dclk_out` with a 50 % duty cycle. Each half-period lasts `FAST_HALF << (7 - rate_sel)` system clocks: rate 7 is the fastest and rate 0 is 128 times slower.
- R3: In synchronous Manchester each half-period lasts twice the NRZ half-period for the same rate code. The line symbol rate is then twice the bit rate.
- R4: In synchronous transmit, `dio_in` is sampled at the rising edge of `dclk_out`. In NRZ, `mod_out` holds the sampled bit for the whole following bit period, starting at the next falling edge of `dclk_out`.
- R5: In synchronous Manchester transmit, during the bit period that follows the sample, `mod_out` equals the sampled bit while `dclk_out` is low and its inverse while `dclk_out` is high. A 0 therefore goes low then high, and a 1 goes high then low.
- R6: In synchronous receive, `dem_bit` is sampled at the rising edge of `dclk_out`. `dio_out` presents it from the next falling edge for a whole bit period. `dio_oe` is 1 and `mod_out` is 0.
- R7: `dio_oe` is 0 in transmit, in every format, and in transparent receive.
- R8: In transparent transmit, `mod_out` follows `dio_in` within the same cycle and `dclk_out` is 0.
- R9: In transparent receive, `dclk_out` follows `dem_bit` within the same cycle and `dio_oe` is 0.
- R10: A change of `mode_sel` or `rate_sel` takes effect only at the next falling edge of `dclk_out`. The half-period already in progress and the high half that follows keep the old length.
- R11: A change of `dir_rx` restarts the bit clock one system clock later. `dclk_out` goes low, and a full low half-period follows, whose length comes from the `mode_sel` and `rate_sel` values present at the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Line format request: 0 NRZ, 1 Manchester, 2 or 3 transparent |
| rate_sel | input | RATE_W | Bit-rate code, 0 slowest and 7 fastest |
| dir_rx | input | 1 | Direction: 1 receive, 0 transmit |
| dio_in | input | 1 | Host data line, input side |
| dio_out | output | 1 | Host data line, output side |
| dio_oe | output | 1 | Output enable for the host data line |
| dclk_out | output | 1 | Bit clock, or raw receive data in transparent mode |
| dem_bit | input | 1 | Bit from the demodulator |
| mod_out | output | 1 | Bit to the modulator |

## Verification
The bench changes the format in the middle of a bit and measures the remaining half-periods. A design that applied the change at once would shorten or stretch the bit that is already on the line. It flips direction while the clock is high and expects an immediate low phase of the newly requested length; a design that kept the old phase would hand the host a runt clock pulse. Manchester transmit is checked in both halves of every bit, which catches an inverted symbol convention or a transition placed on the wrong edge. In transparent mode the bench checks that the data line stays released and that the clock pin follows the raw demodulator level within the same cycle.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

  typedef enum logic [1:0] {
    FMT_NRZ    = 2'd0,
    FMT_MANCH  = 2'd1,
    FMT_RAW    = 2'd2,
    FMT_RAW_HI = 2'd3
  } fmt_e;

  function automatic logic fmt_is_sync(fmt_e f);
    return !f[1];
  endfunction

endpackage

// File: rtl/rdp_bitclk.sv
module rdp_bitclk
  import rdp_pkg::*;
#(
  parameter int FAST_HALF = 2,
  parameter int RATE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              mode_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              dir_rx,
  output logic              phase,
  output logic              rise_tick,
  output logic              fall_tick,
  output logic              restart,
  output fmt_e              act_mode,
  output logic [RATE_W-1:0] act_rate,
  output logic              dir_q
);

  localparam int NUM_RATES = 1 << RATE_W;
  localparam int MAX_HALF  = FAST_HALF * (1 << (NUM_RATES - 1)) * 2;
  localparam int CNT_W     = $clog2(MAX_HALF + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              phase_q, phase_d;
  fmt_e              mode_q, mode_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              dir_d;
  logic [RATE_W-1:0] shamt;
  logic [CNT_W-1:0]  half_len;
  logic              at_end;

  // half-period length from the active configuration
  always_comb begin
    shamt    = RATE_W'(NUM_RATES - 1) - rate_q;
    half_len = CNT_W'(FAST_HALF) << shamt;
    if (mode_q == FMT_MANCH) half_len = half_len << 1;
  end

  always_comb begin
    restart   = (dir_rx != dir_q);
    at_end    = (cnt_q == (half_len - CNT_W'(1)));
    rise_tick = !restart && at_end && !phase_q;
    fall_tick = !restart && at_end &&  phase_q;

    cnt_d   = cnt_q;
    phase_d = phase_q;
    mode_d  = mode_q;
    rate_d  = rate_q;
    dir_d   = dir_q;

    if (restart) begin
      cnt_d   = '0;
      phase_d = 1'b0;
      dir_d   = dir_rx;
      mode_d  = mode_sel;
      rate_d  = rate_sel;
    end else if (at_end) begin
      cnt_d   = '0;
      phase_d = !phase_q;
      if (phase_q) begin
        mode_d = mode_sel;
        rate_d = rate_sel;
      end
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
      mode_q  <= FMT_NRZ;
      rate_q  <= '0;
      dir_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      mode_q  <= mode_d;
      rate_q  <= rate_d;
      dir_q   <= dir_d;
    end
  end

  assign phase    = phase_q;
  assign act_mode = mode_q;
  assign act_rate = rate_q;

endmodule

// File: rtl/rdp_bit_stage.sv
module rdp_bit_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic rise_tick,
  input  logic fall_tick,
  input  logic bit_in,
  output logic bit_out
);

  logic cap_q, cap_d, cap_en;
  logic cur_q, cur_d, cur_en;

  always_comb begin
    cap_en = restart || rise_tick;
    cap_d  = restart ? 1'b0 : bit_in;
    cur_en = restart || fall_tick;
    cur_d  = restart ? 1'b0 : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
    end else if (cap_en) begin
      cap_q <= cap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= 1'b0;
    end else if (cur_en) begin
      cur_q <= cur_d;
    end
  end

  assign bit_out = cur_q;

endmodule

// File: rtl/rdp_pin_mux.sv
module rdp_pin_mux
  import rdp_pkg::*;
(
  input  fmt_e act_mode,
  input  logic dir_q,
  input  logic phase,
  input  logic tx_cur,
  input  logic rx_cur,
  input  logic dio_in,
  input  logic dem_bit,
  output logic dclk_out,
  output logic dio_out,
  output logic dio_oe,
  output logic mod_out
);

  logic sync_fmt;

  always_comb begin
    sync_fmt = fmt_is_sync(act_mode);
    dio_oe   = sync_fmt && dir_q;
    dio_out  = dio_oe ? rx_cur : 1'b0;

    if (sync_fmt)   dclk_out = phase;
    else if (dir_q) dclk_out = dem_bit;
    else            dclk_out = 1'b0;

    if (dir_q)                      mod_out = 1'b0;
    else if (!sync_fmt)             mod_out = dio_in;
    else if (act_mode == FMT_MANCH) mod_out = tx_cur ^ phase;
    else                            mod_out = tx_cur;
  end

endmodule

// File: rtl/radio_data_port.sv
module radio_data_port
  import rdp_pkg::*;
#(
  parameter int FAST_HALF = 2,
  parameter int RATE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              dir_rx,
  input  logic              dio_in,
  output logic              dio_out,
  output logic              dio_oe,
  output logic              dclk_out,
  input  logic              dem_bit,
  output logic              mod_out
);

  logic              phase, rise_tick, fall_tick, restart, dir_q;
  fmt_e              act_mode;
  logic [RATE_W-1:0] act_rate;
  logic              tx_cur, rx_cur;

  rdp_bitclk #(.FAST_HALF(FAST_HALF), .RATE_W(RATE_W)) u_bitclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (fmt_e'(mode_sel)),
    .rate_sel  (rate_sel),
    .dir_rx    (dir_rx),
    .phase     (phase),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .restart   (restart),
    .act_mode  (act_mode),
    .act_rate  (act_rate),
    .dir_q     (dir_q)
  );

  rdp_bit_stage u_tx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .bit_in    (dio_in),
    .bit_out   (tx_cur)
  );

  rdp_bit_stage u_rx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .bit_in    (dem_bit),
    .bit_out   (rx_cur)
  );

  rdp_pin_mux u_pin_mux (
    .act_mode (act_mode),
    .dir_q    (dir_q),
    .phase    (phase),
    .tx_cur   (tx_cur),
    .rx_cur   (rx_cur),
    .dio_in   (dio_in),
    .dem_bit  (dem_bit),
    .dclk_out (dclk_out),
    .dio_out  (dio_out),
    .dio_oe   (dio_oe),
    .mod_out  (mod_out)
  );

endmodule

// File: rtl/rdp_checker.sv
module rdp_checker #(
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_rx,
  input logic              dio_oe,
  input logic              dio_out,
  input logic              mod_out,
  input logic              dclk_out,
  input logic [1:0]        act_mode,
  input logic [RATE_W-1:0] act_rate,
  input logic              dir_q,
  input logic              rise_tick,
  input logic              fall_tick,
  input logic              restart
);

  logic nrz_tx, manch_tx, sync_rx;
  assign nrz_tx   = (act_mode == 2'd0) && !dir_q;
  assign manch_tx = (act_mode == 2'd1) && !dir_q;
  assign sync_rx  = !act_mode[1] && dir_q;

  // R10
  cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_mode) || !$stable(act_rate)) |-> $past(fall_tick || restart));

  // R11
  restart_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (act_mode[1] || !dclk_out));

  // R4
  nrz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_tx && $past(nrz_tx) && !$past(fall_tick)) |-> $stable(mod_out));

  // R5
  manch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (manch_tx && $past(manch_tx) && $past(rise_tick)) |-> (mod_out != $past(mod_out)));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rx && $past(sync_rx) && !$past(fall_tick)) |-> $stable(dio_out));

  // R7
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_rx && $past(!dir_rx)) |-> !dio_oe);

endmodule

bind radio_data_port rdp_checker #(.RATE_W(RATE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dir_rx    (dir_rx),
  .dio_oe    (dio_oe),
  .dio_out   (dio_out),
  .mod_out   (mod_out),
  .dclk_out  (dclk_out),
  .act_mode  (act_mode),
  .act_rate  (act_rate),
  .dir_q     (dir_q),
  .rise_tick (rise_tick),
  .fall_tick (fall_tick),
  .restart   (restart)
);

// File: tb/radio_data_port_tb.sv
`timescale 1ns/1ps
module radio_data_port_tb;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic [2:0] rate_sel;
  logic       dir_rx, dio_in, dem_bit;
  logic       dio_out, dio_oe, dclk_out, mod_out;

  int checks = 0;
  int fails  = 0;

  // columns: format code, rate code, expected half-period in clocks (FAST_HALF = 2)
  localparam int NVEC = 6;
  localparam int VEC [NVEC][3] = '{
    '{0, 7, 2}, '{0, 5, 8}, '{0, 0, 256},
    '{1, 7, 4}, '{1, 3, 64}, '{1, 0, 512}
  };

  radio_data_port #(.FAST_HALF(2), .RATE_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rate_sel(rate_sel),
    .dir_rx(dir_rx), .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe),
    .dclk_out(dclk_out), .dem_bit(dem_bit), .mod_out(mod_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic wait_level(input logic lvl);
    while (dclk_out !== lvl) @(negedge clk);
  endtask

  task automatic wait_fall();
    wait_level(1'b1);
    wait_level(1'b0);
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (dclk_out === lvl) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d cycles expected=completion", 150000);
    report();
  end

  initial begin
    int n;
    logic [7:0] pat;
    rst_n = 1'b0; mode_sel = 2'd0; rate_sel = 3'd0;
    dir_rx = 1'b0; dio_in = 1'b0; dem_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 dclk in reset", dclk_out, 0);
    chk("R1 oe in reset", dio_oe, 0);
    chk("R1 mod in reset", mod_out, 0);
    chk("R1 dio_out in reset", dio_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 dclk after release", dclk_out, 0);

    // rate table walk, transmit direction
    for (int v = 0; v < NVEC; v++) begin
      mode_sel = VEC[v][0][1:0];
      rate_sel = VEC[v][1][2:0];
      wait_fall();
      wait_fall();
      count_level(1'b0, n);
      chk(VEC[v][0] == 1 ? "R3 manch low half" : "R2 nrz low half", n, VEC[v][2]);
      count_level(1'b1, n);
      chk(VEC[v][0] == 1 ? "R3 manch high half" : "R2 nrz high half", n, VEC[v][2]);
    end

    // R4 NRZ transmit
    pat = 8'b1011_0010;
    mode_sel = 2'd0; rate_sel = 3'd5;
    wait_fall(); wait_fall();
    for (int i = 0; i <= 8; i++) begin
      wait_fall();
      if (i > 0) chk("R4 nrz tx bit", mod_out, int'(pat[i-1]));
      chk("R7 oe in tx", dio_oe, 0);
      if (i < 8) dio_in = pat[i];
    end

    // R5 Manchester transmit
    pat = 8'b0110_0111;
    mode_sel = 2'd1;
    wait_fall(); wait_fall();
    for (int i = 0; i <= 8; i++) begin
      wait_fall();
      if (i > 0) chk("R5 manch first half", mod_out, int'(pat[i-1]));
      if (i < 8) dio_in = pat[i];
      wait_level(1'b1);
      if (i > 0) chk("R5 manch second half", mod_out, int'(!pat[i-1]));
    end

    // R10 format change in mid-bit
    mode_sel = 2'd0; rate_sel = 3'd3;
    wait_fall(); wait_fall();
    mode_sel = 2'd1;
    count_level(1'b0, n);
    chk("R10 low half after change", n, 32);
    count_level(1'b1, n);
    chk("R10 high half after change", n, 32);
    count_level(1'b0, n);
    chk("R10 low half at new format", n, 64);

    // R11 direction switch while clock high
    mode_sel = 2'd0; rate_sel = 3'd4;
    wait_fall(); wait_fall();
    wait_level(1'b1);
    repeat (4) @(negedge clk);
    dir_rx = 1'b1; mode_sel = 2'd1;
    @(negedge clk);
    chk("R11 dclk low after switch", dclk_out, 0);
    chk("R6 oe in sync rx", dio_oe, 1);
    count_level(1'b0, n);
    chk("R11 full low half with new format", n, 32);

    // R6 receive, Manchester then NRZ
    for (int m = 1; m >= 0; m--) begin
      pat = (m == 1) ? 8'b0110_1001 : 8'b1100_0101;
      mode_sel = 2'(m); rate_sel = 3'd5;
      wait_fall(); wait_fall();
      for (int i = 0; i <= 8; i++) begin
        wait_fall();
        if (i > 0) chk("R6 rx bit", dio_out, int'(pat[i-1]));
        chk("R6 oe in rx", dio_oe, 1);
        chk("R6 mod idle in rx", mod_out, 0);
        if (i < 8) dem_bit = pat[i];
      end
    end

    // R9 transparent receive
    mode_sel = 2'd2; rate_sel = 3'd7;
    repeat (80) @(negedge clk);
    chk("R9 oe in raw rx", dio_oe, 0);
    for (int i = 0; i < 4; i++) begin
      dem_bit = ~dem_bit;
      #1;
      chk("R9 dclk follows dem", dclk_out, int'(dem_bit));
      chk("R9 oe stays off", dio_oe, 0);
      @(negedge clk);
    end

    // R8 transparent transmit
    dir_rx = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      dio_in = ~dio_in;
      #1;
      chk("R8 mod follows dio", mod_out, int'(dio_in));
      chk("R8 dclk idle", dclk_out, 0);
      chk("R7 oe in raw tx", dio_oe, 0);
      @(negedge clk);
    end

    report();
  end

endmodule